// File: doc/BRIEF.md
# Dual-Bank Shadowed Register File

This block is a data register file with two banks of equal size: a primary bank and a secondary (shadow) bank. One bank is active at any time. Reads and writes reach only the active bank. Software changes banks by flipping one bit of a mode word. An interrupt handler can therefore take over a clean set of working registers in a single cycle, without spilling the interrupted code's values to memory.

Several compute units and memory paths can use the file in the same cycle through six read ports and four write ports.

- **Reads** are combinational. They return the value held before any write that is in flight in the same cycle.
- **Writes** land on the rising clock edge. When write ports collide on one register, a fixed priority decides the result.

Top module: `shadow_regfile`

## Requirements
- R1: While reset is asserted, and on the cycle it is released, the primary bank is active whatever the mode word says. Every register of both banks reads zero after reset.
- R2: Each read port presents the active-bank register selected by its address in the same cycle, with no clock edge needed.
- R3: A write with its enable high stores its data into the addressed register of the active bank at the next rising clock edge. A read of that register in the same cycle returns the previous content, because there is no bypass.
- R4: When several enabled write ports address the same register in one cycle, the port with the highest index decides the stored value.
- R5: Bit 3 of the mode word selects the bank: 0 for primary, 1 for secondary. A change of that bit takes effect one clock edge later. Writes issued in the cycle of the change still go to the bank that was active in that cycle.
- R6: The registers of the inactive bank keep their contents while the other bank is in use and being written.
- R7: A write port whose enable is low changes no register, whatever its address and data.
- R8: All six read ports are independent. Several ports given the same address return the same value.
- R9: Mode word bits other than bit 3 have no effect on which bank is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | MODE_W (8) | Mode word; bit BANK_BIT (3) picks the bank |
| rd_addr_i | input | NRD x AW (6 x 4) | Register address for each read port |
| rd_data_o | output | NRD x DW (6 x 40) | Read data for each read port |
| wr_en_i | input | NWR (4) | Write enable for each write port |
| wr_addr_i | input | NWR x AW (4 x 4) | Register address for each write port |
| wr_data_i | input | NWR x DW (4 x 40) | Write data for each write port |

## Verification
The bench builds the file with its defaults: 16 registers per bank, 40-bit words, six read and four write ports, and the bank bit at position 3 of an 8-bit mode word.

Four write ports make two-way, three-way and four-way collisions on one register reachable. Six read ports allow the same address on every port at once, or each write address to be read back through two ports while the write is pending.

Data words use the upper byte of the 40 bits, so a truncation to 32 bits would show. The 8-bit mode word leaves seven unrelated bits to toggle against the bank bit.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic {
    BANK_PRI = 1'b0,
    BANK_SEC = 1'b1
  } bank_e;

  localparam int NUM_BANKS = 2;

endpackage

// File: rtl/rf_bank_ctl.sv
module rf_bank_ctl
  import rf_pkg::*;
#(
  parameter int MODE_W   = 8,
  parameter int BANK_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);

  bank_e bank_q;

  // registered selection: a mode change is seen by the file one edge later
  always_ff @(posedge clk) begin
    if (!rst_n) bank_q <= BANK_PRI;
    else        bank_q <= bank_e'(mode_i[BANK_BIT]);
  end

  assign bank_o = bank_q;

  // R5: the active bank follows the bank bit of the previous cycle
  p_bank_follows_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bank_q == bank_e'($past(mode_i[BANK_BIT]))));

  // R1: the cycle after any reset cycle finds the primary bank active
  p_reset_primary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) == 1'b0) |-> (bank_q == BANK_PRI));

endmodule

// File: rtl/rf_write_arb.sv
module rf_write_arb #(
  parameter int NREG = 16,
  parameter int NWR  = 4,
  parameter int AW   = 4,
  parameter int DW   = 40
) (
  input  logic [NWR-1:0]           wr_en_i,
  input  logic [NWR-1:0][AW-1:0]   wr_addr_i,
  input  logic [NWR-1:0][DW-1:0]   wr_data_i,
  output logic [NREG-1:0]          reg_we_o,
  output logic [NREG-1:0][DW-1:0]  reg_wd_o
);

  localparam int PW = (NWR > 1) ? $clog2(NWR) : 1;

  // returns {hit, index} of the last enabled port aiming at register r
  function automatic logic [PW:0] last_writer(
    input logic [NWR-1:0]         en,
    input logic [NWR-1:0][AW-1:0] addr,
    input int unsigned            r
  );
    logic [PW:0] res;
    res = '0;
    for (int p = 0; p < NWR; p++) begin
      if (en[p] && (addr[p] == AW'(r))) res = {1'b1, PW'(p)};
    end
    return res;
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [PW:0] sel;
    always_comb begin
      sel         = last_writer(wr_en_i, wr_addr_i, r);
      reg_we_o[r] = sel[PW];
      reg_wd_o[r] = wr_data_i[sel[PW-1:0]];
      // R4: the top write port always decides a register it addresses
      if (wr_en_i[NWR-1] && (wr_addr_i[NWR-1] == AW'(r))) begin
        p_top_port_wins_r4: assert (reg_we_o[r] && (reg_wd_o[r] == wr_data_i[NWR-1]));
      end
      // R7: no enabled port aiming here means no write request
      if (wr_en_i == '0) begin
        p_idle_no_write_r7: assert (!reg_we_o[r]);
      end
    end
  end

endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store
  import rf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 40,
  parameter int AW   = 4,
  parameter int NRD  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bank_e                    act_bank_i,
  input  logic [NREG-1:0]          reg_we_i,
  input  logic [NREG-1:0][DW-1:0]  reg_wd_i,
  input  logic [NRD-1:0][AW-1:0]   rd_addr_i,
  output logic [NRD-1:0][DW-1:0]   rd_data_o
);

  logic [DW-1:0] mem [NUM_BANKS][NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int r = 0; r < NREG; r++)
          mem[b][r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++)
        if (reg_we_i[r]) mem[act_bank_i][r] <= reg_wd_i[r];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb rd_data_o[p] = mem[act_bank_i][rd_addr_i[p]];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < NREG; r++) begin : g_cell
      // R3: a granted write into the active bank lands at the next edge
      p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i[r] && (act_bank_i == bank_e'(b))) |=> (mem[b][r] == $past(reg_wd_i[r])));
      // R6: the bank that is not active keeps its value
      p_inactive_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_bank_i != bank_e'(b)) |=> $stable(mem[b][r]));
      // R7: no write request, no change
      p_no_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we_i[r]) |=> $stable(mem[b][r]));
    end
  end

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import rf_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int DW       = 40,
  parameter int NRD      = 6,
  parameter int NWR      = 4,
  parameter int MODE_W   = 8,
  parameter int BANK_BIT = 3,
  localparam int AW      = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic [NRD-1:0][AW-1:0]  rd_addr_i,
  output logic [NRD-1:0][DW-1:0]  rd_data_o,
  input  logic [NWR-1:0]          wr_en_i,
  input  logic [NWR-1:0][AW-1:0]  wr_addr_i,
  input  logic [NWR-1:0][DW-1:0]  wr_data_i
);

  bank_e                   act_bank;
  logic [NREG-1:0]         reg_we;
  logic [NREG-1:0][DW-1:0] reg_wd;

  rf_bank_ctl #(
    .MODE_W   (MODE_W),
    .BANK_BIT (BANK_BIT)
  ) i_bank_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .bank_o (act_bank)
  );

  rf_write_arb #(
    .NREG (NREG),
    .NWR  (NWR),
    .AW   (AW),
    .DW   (DW)
  ) i_write_arb (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .reg_we_o  (reg_we),
    .reg_wd_o  (reg_wd)
  );

  rf_bank_store #(
    .NREG (NREG),
    .DW   (DW),
    .AW   (AW),
    .NRD  (NRD)
  ) i_bank_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_bank_i (act_bank),
    .reg_we_i   (reg_we),
    .reg_wd_i   (reg_wd),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  // R8: read ports sharing an address agree
  for (genvar p = 1; p < NRD; p++) begin : g_rd_agree
    always_comb begin
      if (rd_addr_i[p] == rd_addr_i[0]) begin
        p_ports_agree_r8: assert (rd_data_o[p] == rd_data_o[0]);
      end
    end
  end

endmodule

// File: tb/test_shadow_regfile.sv
`timescale 1ns/1ps
module test_shadow_regfile;

  localparam int NREG = 16;
  localparam int DW   = 40;
  localparam int NRD  = 6;
  localparam int NWR  = 4;
  localparam int AW   = 4;

  typedef struct packed {
    logic        bank;
    logic [3:0]  en;
    logic [15:0] wa;   // port p address in wa[4p+3:4p]
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'b1111, 16'h3210},   // plain writes, primary
    '{1'b0, 4'b0101, 16'h7654},   // partial enables
    '{1'b1, 4'b1111, 16'h89AB},   // switch requested, writes still primary
    '{1'b1, 4'b1111, 16'h0123},   // secondary now active
    '{1'b1, 4'b1100, 16'hFF55},   // ports 3 and 2 collide
    '{1'b0, 4'b0011, 16'h00CC},   // ports 1 and 0 collide, back to primary next
    '{1'b0, 4'b1010, 16'hEEDD},   // disabled ports share targets
    '{1'b0, 4'b0000, 16'h1234}    // all disabled
  };

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [7:0]             mode;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_data;
  logic [NWR-1:0]         wr_en;
  logic [NWR-1:0][AW-1:0] wr_addr;
  logic [NWR-1:0][DW-1:0] wr_data;

  logic [DW-1:0] mdl [2][NREG];
  int            mb;
  int            n_chk  = 0;
  int            n_fail = 0;
  bit            done   = 1'b0;

  always #10 clk = ~clk;

  shadow_regfile i_shadow_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

  function automatic logic [DW-1:0] dat(int i, int p);
    return {8'(i + 1), 8'(p + 16), 24'hABC000 + 24'(i * 4 + p)};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_all(string req);
    for (int r = 0; r < NREG; r++) begin
      rd_addr[r % NRD] = AW'(r);
      #1;
      chk(rd_data[r % NRD] === mdl[mb][r], req, rd_data[r % NRD], mdl[mb][r]);
    end
  endtask

  task automatic go_bank(int b);
    @(negedge clk);
    mode  = 8'(b) << 3;
    wr_en = '0;
    @(posedge clk);
    mb = b;
    #2;
  endtask

  task automatic write_all(int a, logic [NWR-1:0] en, int tag);
    @(negedge clk);
    wr_en = en;
    for (int p = 0; p < NWR; p++) begin
      wr_addr[p] = AW'(a);
      wr_data[p] = dat(tag, p);
    end
    @(posedge clk);
    for (int p = 0; p < NWR; p++) if (en[p]) mdl[mb][a] = dat(tag, p);
    #2;
    wr_en = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    mode    = 8'h08;      // bank bit set during reset: must be ignored (R1)
    wr_en   = '0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    mb      = 0;
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < NREG; r++) mdl[b][r] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    read_all("R1 primary zero in reset");
    mode  = 8'h00;
    rst_n = 1'b1;

    // R1: secondary bank also cleared
    go_bank(1);
    read_all("R1 secondary zero");
    go_bank(0);

    // table walk: R2/R3 old value before edge, model after
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      mode  = {4'b0, VECS[i].bank, 3'b0};
      wr_en = VECS[i].en;
      for (int p = 0; p < NWR; p++) begin
        wr_addr[p] = VECS[i].wa[4*p +: 4];
        wr_data[p] = dat(i, p);
        rd_addr[p] = wr_addr[p];
      end
      rd_addr[4] = wr_addr[0];
      rd_addr[5] = wr_addr[3];
      #2;
      for (int p = 0; p < NRD; p++)
        chk(rd_data[p] === mdl[mb][rd_addr[p]], "R3 old value before edge (R2)",
            rd_data[p], mdl[mb][rd_addr[p]]);
      @(posedge clk);
      for (int p = 0; p < NWR; p++)
        if (VECS[i].en[p]) mdl[mb][VECS[i].wa[4*p +: 4]] = dat(i, p);
      mb = int'(VECS[i].bank);
      #2;
    end
    wr_en = '0;

    // R5/R6: both banks hold their own contents
    go_bank(0);
    read_all("R6 primary after table");
    go_bank(1);
    read_all("R6 secondary after table");
    go_bank(0);

    // R4: four-way collision, top port decides
    write_all(9, 4'b1111, 20);
    rd_addr[0] = 4'd9;
    #1;
    chk(rd_data[0] === dat(20, 3), "R4 four-way collision", rd_data[0], dat(20, 3));
    // R4: ports 0..2 collide, port 2 decides
    write_all(10, 4'b0111, 21);
    rd_addr[1] = 4'd10;
    #1;
    chk(rd_data[1] === dat(21, 2), "R4 three-way collision", rd_data[1], dat(21, 2));

    // R7: disabled ports leave register 9 alone
    write_all(9, 4'b0000, 22);
    rd_addr[2] = 4'd9;
    #1;
    chk(rd_data[2] === dat(20, 3), "R7 disabled write ignored", rd_data[2], dat(20, 3));

    // R5: switch takes effect one edge later
    @(negedge clk);
    mode       = 8'h08;
    rd_addr[3] = 4'd9;
    #2;
    chk(rd_data[3] === mdl[0][9], "R5 before edge still primary", rd_data[3], mdl[0][9]);
    @(posedge clk);
    mb = 1;
    #2;
    chk(rd_data[3] === mdl[1][9], "R5 after edge secondary", rd_data[3], mdl[1][9]);

    // R9: other mode bits do not select the secondary bank
    @(negedge clk);
    mode = 8'hF7;
    @(posedge clk);
    mb = 0;
    #2;
    chk(rd_data[3] === mdl[0][9], "R9 unrelated mode bits ignored", rd_data[3], mdl[0][9]);

    // R8: all ports on one address
    for (int p = 0; p < NRD; p++) rd_addr[p] = 4'd10;
    #1;
    for (int p = 0; p < NRD; p++)
      chk(rd_data[p] === mdl[0][10], "R8 shared address", rd_data[p], mdl[0][10]);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule